// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Condition Flags and Branch Decision

This block pairs an 8-bit arithmetic and logic datapath with a four-bit condition register. It exposes a branch-decision output. Each cycle the caller presents an operation code and two operands, and the result appears combinationally. When the operation is strobed with `op_en`, the condition register captures the carry, sign, zero and overflow conditions of that result at the next rising clock edge.

Add-with-carry and subtract-with-borrow take their incoming carry from the stored carry flag. This allows wider arithmetic to be chained one byte per operation. Subtraction is formed as the first operand plus the inverted second operand plus an incoming carry, so a stored carry of 1 means that no borrow is pending.

The branch-decision output combines one selected stored flag with a polarity bit. It tells a sequencer whether a conditional branch would be taken. It depends only on the stored flags and the two select inputs, not on the operation in flight.

Top module: `alu_flag_unit`

## Requirements
- R1: Op code 0 (add) drives `result` = (a + b) mod 256. Op code 1 (add with carry) drives (a + b + C) mod 256, where C is the stored carry. After a strobed add or add-with-carry, C holds the carry out of bit 7.
- R2: Op code 2 (subtract) drives (a + ~b + 1) mod 256. Op code 3 (subtract with borrow) drives (a + ~b + C) mod 256. After either, C holds the carry out of bit 7, so C = 1 means no borrow.
- R3: Op code 4 (negate) drives the two's complement of `a`, formed as 0 + ~a + 1. Its stored carry is 1 only when a = 0.
- R4: After a strobed arithmetic op (codes 0 to 4), V is 1 exactly when the signed sum of the two adder inputs and the incoming carry lies outside -128..+127. This equals the XOR of the carries into and out of bit 7.
- R5: After any strobed defined op (codes 0 to 8), S equals bit 7 of the result and Z is 1 exactly when all eight result bits are 0.
- R6: The logic ops AND (code 5), OR (6), XOR (7) and NOT of `a` (8) clear V and leave C unchanged.
- R7: Flags change only at a rising edge with `op_en` = 1 and a defined op code. Codes 9 to 15 drive `result` = 0 and leave the flags unchanged.
- R8: `flags` packs C in bit 0, S in bit 1, Z in bit 2 and V in bit 3. `branch_take` equals the flag picked by `cond_sel` (0 = C, 1 = S, 2 = Z, 3 = V), inverted when `cond_neg` = 1. It changes with no clock edge.
- R9: While reset is asserted, and until it has been released for two clock edges, `flags` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_en | input | 1 | Strobe: update the flags with this cycle's operation |
| op_sel | input | 4 | Operation code |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 8 | Combinational operation result |
| flags | output | 4 | Stored flags {V, Z, S, C} |
| cond_sel | input | 2 | Flag selected for the branch test |
| cond_neg | input | 1 | 1 tests for the flag being 0 |
| branch_take | output | 1 | Branch would be taken |

## Verification
Every value of `a` is swept against nineteen values of `b`. These are multiples of 0x11 plus 0x01, 0x7F and 0x80, which separate signed overflow in both directions from plain carry. Within each operand pair the operations run in a fixed chain so that the carry-consuming ops see both stored carry values. An add-with-carry placed after a logic op shows whether the carry survived that op. Reserved codes and unstrobed cycles are then checked against the flags and result they must leave alone. After every update, all eight branch select and polarity combinations are compared against the expected flags.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 2;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB = 4'd2;
  localparam logic [OP_W-1:0] OP_SBB = 4'd3;
  localparam logic [OP_W-1:0] OP_NEG = 4'd4;
  localparam logic [OP_W-1:0] OP_AND = 4'd5;
  localparam logic [OP_W-1:0] OP_OR  = 4'd6;
  localparam logic [OP_W-1:0] OP_XOR = 4'd7;
  localparam logic [OP_W-1:0] OP_NOT = 4'd8;

  // bit 0 is carry, bit 3 is overflow
  typedef struct packed {
    logic v;
    logic z;
    logic s;
    logic c;
  } cond_flags_t;

  localparam int FLAG_W = $bits(cond_flags_t);

  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return op <= OP_NEG;
  endfunction

  function automatic logic op_is_logic(input logic [OP_W-1:0] op);
    return (op >= OP_AND) && (op <= OP_NOT);
  endfunction
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_stored,
  output logic [WIDTH-1:0] res,
  output logic             carry_out,
  output logic             ovf_out,
  output logic             upd_arith,
  output logic             upd_logic
);
  localparam int LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] add_x, add_y;
  logic             add_cin;
  logic [WIDTH-1:0] low_sum;
  logic             carry_msb;
  logic [1:0]       msb_sum;
  logic [WIDTH-1:0] sum_word;
  logic [WIDTH-1:0] logic_word;

  // adder input steering
  always_comb begin
    add_x   = opa;
    add_y   = opb;
    add_cin = 1'b0;
    unique case (op)
      OP_ADC: add_cin = carry_stored;
      OP_SUB: begin add_y = ~opb; add_cin = 1'b1; end
      OP_SBB: begin add_y = ~opb; add_cin = carry_stored; end
      OP_NEG: begin add_x = '0; add_y = ~opa; add_cin = 1'b1; end
      default: ;
    endcase
  end

  // split adder exposes carry into the top bit
  always_comb begin
    low_sum   = {1'b0, add_x[LOW_W-1:0]} + {1'b0, add_y[LOW_W-1:0]}
              + {{LOW_W{1'b0}}, add_cin};
    carry_msb = low_sum[LOW_W];
    msb_sum   = {1'b0, add_x[WIDTH-1]} + {1'b0, add_y[WIDTH-1]} + {1'b0, carry_msb};
    sum_word  = {msb_sum[0], low_sum[LOW_W-1:0]};
    carry_out = msb_sum[1];
    ovf_out   = msb_sum[1] ^ carry_msb;
  end

  always_comb begin
    logic_word = '0;
    unique case (op)
      OP_AND:  logic_word = opa & opb;
      OP_OR:   logic_word = opa | opb;
      OP_XOR:  logic_word = opa ^ opb;
      OP_NOT:  logic_word = ~opa;
      default: logic_word = '0;
    endcase
  end

  always_comb begin
    upd_arith = op_is_arith(op);
    upd_logic = op_is_logic(op);
    if (upd_arith)      res = sum_word;
    else if (upd_logic) res = logic_word;
    else                res = '0;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             upd_arith,
  input  logic             upd_logic,
  input  logic [WIDTH-1:0] res,
  input  logic             carry_in,
  input  logic             ovf_in,
  output cond_flags_t      q
);
  cond_flags_t d;
  logic        load;

  always_comb begin
    d    = q;
    load = en && (upd_arith || upd_logic);
    if (load) begin
      d.s = res[WIDTH-1];
      d.z = (res == '0);
      if (upd_arith) begin
        d.c = carry_in;
        d.v = ovf_in;
      end else begin
        d.v = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R6
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd_logic) |=> (q.c == $past(q.c)));

  // R6
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && upd_logic) |=> !q.v);
endmodule

// File: rtl/alu_branch_eval.sv
module alu_branch_eval
  import alu_flag_pkg::*;
(
  input  cond_flags_t      fl,
  input  logic [SEL_W-1:0] sel,
  input  logic             neg,
  output logic             take
);
  logic picked;

  always_comb begin
    unique case (sel)
      2'd0: picked = fl.c;
      2'd1: picked = fl.s;
      2'd2: picked = fl.z;
      default: picked = fl.v;
    endcase
    take = picked ^ neg;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic [FLAG_W-1:0] flags,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             cond_neg,
  output logic             branch_take
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  cond_flags_t            fl_q;
  logic                   dp_carry, dp_ovf, dp_arith, dp_logic;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .op(op_sel), .opa(a), .opb(b), .carry_stored(fl_q.c),
    .res(result), .carry_out(dp_carry), .ovf_out(dp_ovf),
    .upd_arith(dp_arith), .upd_logic(dp_logic)
  );

  alu_flag_reg #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_s_n), .en(op_en),
    .upd_arith(dp_arith), .upd_logic(dp_logic), .res(result),
    .carry_in(dp_carry), .ovf_in(dp_ovf), .q(fl_q)
  );

  alu_branch_eval u_br (
    .fl(fl_q), .sel(cond_sel), .neg(cond_neg), .take(branch_take)
  );

  assign flags = fl_q;

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!op_en || op_sel > OP_NOT) |=> $stable(flags));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_en && op_sel <= OP_NOT) |=> (flags[2] == ($past(result) == '0)));

  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_en && op_sel <= OP_NOT) |=> (flags[1] == $past(result[WIDTH-1])));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (op_sel > OP_NOT) |-> (result == '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_s_n |-> (flags == '0));
endmodule

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/100ps
module alu_flag_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_en;
  logic [3:0] op_sel;
  logic [7:0] a, b, result;
  logic [3:0] flags;
  logic [1:0] cond_sel;
  logic       cond_neg;
  logic       branch_take;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [3:0] mflags;   // expected {V,Z,S,C}

  always #2 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel), .a(a), .b(b),
    .result(result), .flags(flags), .cond_sel(cond_sel), .cond_neg(cond_neg),
    .branch_take(branch_take)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // R8: all eight select/polarity combinations against expected flags
  task automatic check_branch();
    for (int cs = 0; cs < 4; cs++) begin
      for (int cn = 0; cn < 2; cn++) begin
        cond_sel = cs[1:0];
        cond_neg = cn[0];
        #0.1;
        chk(branch_take == (mflags[cs] ^ cn[0]), "R8 branch", branch_take, mflags[cs] ^ cn[0]);
      end
    end
  endtask

  // called just after a falling edge
  task automatic run(input int op, input int va, input int vb, input bit en);
    int x, y, cin, sum, ssum, eres;
    bit arith, logical;
    string req;
    op_sel = op[3:0]; a = va[7:0]; b = vb[7:0]; op_en = en;
    x = va; y = vb; cin = 0; arith = (op <= 4); logical = (op >= 5 && op <= 8);
    case (op)
      1: cin = mflags[0];
      2: begin y = (~vb) & 255; cin = 1; end
      3: begin y = (~vb) & 255; cin = mflags[0]; end
      4: begin x = 0; y = (~va) & 255; cin = 1; end
      default: ;
    endcase
    sum  = x + y + cin;
    ssum = sgn(x) + sgn(y) + cin;
    case (op)
      5: eres = va & vb;
      6: eres = va | vb;
      7: eres = va ^ vb;
      8: eres = (~va) & 255;
      default: eres = arith ? (sum & 255) : 0;
    endcase
    req = (op <= 1) ? "R1" : (op <= 3) ? "R2" : (op == 4) ? "R3" : (op <= 8) ? "R6" : "R7";
    #0.2;
    chk(result == eres[7:0], {req, " result"}, result, eres);
    if (en && (arith || logical)) begin
      mflags[1] = eres[7];
      mflags[2] = (eres == 0);
      if (arith) begin
        mflags[0] = sum[8];
        mflags[3] = (ssum > 127) || (ssum < -128);
      end else begin
        mflags[3] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    #0.1;
    chk(flags[0] == mflags[0], {req, " carry"}, flags, mflags);
    chk(flags[3] == mflags[3], arith ? "R4 overflow" : {req, " overflow"}, flags, mflags);
    chk(flags[2:1] == mflags[2:1], en ? "R5 sign/zero" : "R7 hold", flags, mflags);
    check_branch();
  endtask

  function automatic int bval(input int j);
    if (j < 16) return j * 17;
    if (j == 16) return 1;
    if (j == 17) return 127;
    return 128;
  endfunction

  initial begin
    rst_n = 1'b0; op_en = 1'b0; op_sel = 4'd0; a = 8'h00; b = 8'h00;
    cond_sel = 2'd0; cond_neg = 1'b0; mflags = 4'b0000;
    repeat (3) @(negedge clk);
    #0.1;
    chk(flags == 4'b0000, "R9 reset flags", flags, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #0.1;
    chk(flags == 4'b0000, "R9 sync release", flags, 0);
    repeat (2) @(negedge clk);
    #0.1;
    check_branch();

    for (int ia = 0; ia < 256; ia++) begin
      for (int j = 0; j < 19; j++) begin
        int vb;
        vb = bval(j);
        run(0, ia, vb, 1);   // R1 add
        run(1, ia, vb, 1);   // R1 add with carry from previous add
        run(2, ia, vb, 1);   // R2 subtract
        run(3, ia, vb, 1);   // R2 subtract with borrow
        run(4, ia, vb, 1);   // R3 negate
        run(5, ia, vb, 1);   // R6 and
        run(1, ia, vb, 1);   // R6 carry preserved through logic op
        run(6, ia, vb, 1);
        run(7, ia, vb, 1);
        run(8, ia, vb, 1);
        run(3, ia, vb, 1);
      end
    end

    // R7: unstrobed defined ops and strobed reserved codes leave flags alone
    run(0, 8'hFF, 8'h01, 1);
    run(0, 8'h00, 8'h00, 0);
    run(2, 8'h80, 8'h01, 0);
    for (int op = 9; op < 16; op++) begin
      run(op, 8'h00, 8'h00, 1);
      run(op, 8'h7F, 8'h01, 0);
    end
    run(4, 8'h80, 8'h00, 1);
    for (int op = 9; op < 16; op++) run(op, 8'hA5, 8'h5A, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule